// File: doc/BRIEF.md
# Auto-negotiation arbitration engine

This block makes the decisions of 10/100 Mbit/s copper auto-negotiation. A separate pulse receiver hands it decoded 16-bit link code words, and line-side detectors report when a plain 10BASE-T or 100BASE-TX idle is present. The engine keeps the local advertisement word and a small control word with an enable bit and a self-clearing restart bit. It produces the word the transmitter should send, with the acknowledge bit (bit 14) filled in, and it asks the transmitter to keep sending it while negotiation is in progress.

Negotiation has two matching phases. First, three consecutive received words must agree when bit 14 is ignored; that word is then stored as the partner's abilities, and the local acknowledge goes out. Second, three consecutive acknowledged copies of the stored word must arrive. The engine then picks the best technology both sides offer. A plain idle seen during the first phase settles the link at half duplex by parallel detection. No shared technology, or a timeout, raises the failure flag and starts again from the beginning. A loss of link after completion also starts again.

All outputs come from registers. An input sampled at a clock edge is reflected on the outputs right after that edge.

Top module: `autoneg_arbiter`

## Requirements
- R1: After reset: enable reads 1, restart reads 0, the advertisement word reads 0x01E1 (ability bits 8..5 set, selector 00001), tx_req_o is 1, and tx_word_o, done_o, fail_o and lp_valid_o read 0x01E1, 0, 0 and 0.
- R2: In the first phase, a word received while the candidate count is non-zero and equal to the candidate with bit 14 masked raises the count. Any other word becomes the new candidate with a count of one. The third matching word is stored, as received, in lp_word_o, and lp_valid_o rises.
- R3: tx_word_o equals the advertisement word with bit 14 replaced by the acknowledge flag. The flag is set from the cycle the partner word is stored until negotiation restarts.
- R4: In the acknowledge phase, a word with bit 14 set that equals the stored word (bit 14 masked) raises the count. Any other word clears the count to zero. The third such word completes resolution.
- R5: Resolution takes the highest set bit of (advertisement[8:5] AND partner[8:5]). The order is bit 8 (100 full), bit 7 (100 half), bit 6 (10 full), bit 5 (10 half). It reports speed100_o=1 for 100 Mbit/s and full_dup_o=1 for full duplex, together with done_o=1.
- R6: If no ability bit is shared at resolution, fail_o goes to 1 and negotiation restarts from the beginning: lp_valid_o=0, acknowledge cleared, done_o=0.
- R7: During the first phase, idle100_i completes with 100 Mbit/s half duplex and idle10_i completes with 10 Mbit/s half duplex. idle100_i wins when both are present. Idle inputs have no effect in the other phases.
- R8: If negotiation has not completed TIMEOUT_CYC cycles after it starts, fail_o goes to 1 and negotiation restarts.
- R9: Writing 1 to the restart bit makes ctl_restart_o read 1 for one cycle. On the following edge negotiation restarts from the beginning and fail_o clears.
- R10: With enable written to 0, negotiation stops: tx_req_o, done_o and fail_o go to 0, and received words and idle inputs have no effect. Writing enable back to 1 restarts negotiation.
- R11: If link_ok_i is low while done_o is 1, negotiation restarts from the beginning.
- R12: The advertisement word is writable. The new value appears on adv_o and tx_word_o and is used by the next resolution.
- R13: A successful completion clears fail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| ctl_en_wd_i | input | 1 | Enable value to write |
| ctl_restart_wd_i | input | 1 | Restart value to write (1 restarts) |
| adv_wr_i | input | 1 | Write strobe for the advertisement word |
| adv_wd_i | input | 16 | Advertisement value to write |
| rx_valid_i | input | 1 | A decoded partner word is present this cycle |
| rx_word_i | input | 16 | Decoded partner link code word |
| idle10_i | input | 1 | 10BASE-T idle detected |
| idle100_i | input | 1 | 100BASE-TX idle detected |
| link_ok_i | input | 1 | Link currently up |
| ctl_en_o | output | 1 | Enable bit readback |
| ctl_restart_o | output | 1 | Restart bit readback (self-clearing) |
| adv_o | output | 16 | Advertisement word readback |
| tx_req_o | output | 1 | Transmitter should send tx_word_o |
| tx_word_o | output | 16 | Outgoing link code word |
| lp_word_o | output | 16 | Stored partner ability word |
| lp_valid_o | output | 1 | lp_word_o holds a word of this negotiation |
| done_o | output | 1 | Negotiation complete |
| fail_o | output | 1 | Negotiation failed |
| speed100_o | output | 1 | Resolved speed: 1 = 100 Mbit/s |
| full_dup_o | output | 1 | Resolved duplex: 1 = full |

## Verification
A wrong match count shows on lp_valid_o or done_o one word too early or too late. It is visible on the edge that samples the deciding word. A wrong candidate or stored word shows up as a phase that never advances, or as wrong speed and duplex bits. A wrong priority or mask shows up as wrong speed and duplex bits, or as fail_o where a shared ability exists. A drifting timer shows as fail_o rising on a different cycle from the one the requirements predict. Because the bench model predicts every output each cycle, any of these is reported within one clock of the input that exposes it.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;
    localparam int CW_W     = 16;
    localparam int ACK_BIT  = 14;
    localparam int TECH_N   = 4;
    localparam int TECH_LSB = 5;

    typedef logic [CW_W-1:0] cw_t;

    localparam cw_t ACK_MASK = cw_t'(1) << ACK_BIT;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_ABIL = 2'd1,
        PH_ACK  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic en;
        logic rst;
        cw_t  adv;
    } ctl_st_t;

    function automatic cw_t strip_ack(input cw_t w);
        return w & ~ACK_MASK;
    endfunction
endpackage

// File: rtl/an_ctl_regs.sv
module an_ctl_regs
    import an_arb_pkg::*;
#(
    parameter cw_t ADV_RESET = 16'h01E1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctl_i,
    input  logic wd_en_i,
    input  logic wd_restart_i,
    input  logic wr_adv_i,
    input  cw_t  wd_adv_i,
    output logic en_o,
    output logic restart_o,
    output cw_t  adv_o
);
    ctl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rst = wr_ctl_i && wd_restart_i;
        if (wr_ctl_i) begin
            ctl_d.en = wd_en_i;
        end
        if (wr_adv_i) begin
            ctl_d.adv = wd_adv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.en  <= 1'b1;
            ctl_q.rst <= 1'b0;
            ctl_q.adv <= ADV_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign en_o      = ctl_q.en;
    assign restart_o = ctl_q.rst;
    assign adv_o     = ctl_q.adv;

    // R9
    restart_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && !(wr_ctl_i && wd_restart_i)) |=> !restart_o);
endmodule

// File: rtl/an_neg_timer.sv
module an_neg_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !run_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/an_prio_resolve.sv
module an_prio_resolve
    import an_arb_pkg::*;
(
    input  logic [TECH_N-1:0] loc_i,
    input  logic [TECH_N-1:0] lp_i,
    output logic [TECH_N-1:0] pick_o,
    output logic              none_o,
    output logic              spd100_o,
    output logic              fdx_o
);
    logic [TECH_N-1:0] common;

    assign common = loc_i & lp_i;

    for (genvar i = 0; i < TECH_N; i++) begin : g_pick
        assign pick_o[i] = common[i] && !(|(common >> (i + 1)));
    end

    assign none_o   = ~|common;
    // index 3: 100 full, 2: 100 half, 1: 10 full, 0: 10 half
    assign spd100_o = pick_o[3] | pick_o[2];
    assign fdx_o    = pick_o[3] | pick_o[1];
endmodule

// File: rtl/autoneg_arbiter.sv
module autoneg_arbiter
    import an_arb_pkg::*;
#(
    parameter int  MATCH_N     = 3,
    parameter int  TIMEOUT_CYC = 100000,
    parameter cw_t ADV_RESET   = 16'h01E1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_i,
    input  logic        ctl_en_wd_i,
    input  logic        ctl_restart_wd_i,
    input  logic        adv_wr_i,
    input  logic [15:0] adv_wd_i,
    input  logic        rx_valid_i,
    input  logic [15:0] rx_word_i,
    input  logic        idle10_i,
    input  logic        idle100_i,
    input  logic        link_ok_i,
    output logic        ctl_en_o,
    output logic        ctl_restart_o,
    output logic [15:0] adv_o,
    output logic        tx_req_o,
    output logic [15:0] tx_word_o,
    output logic [15:0] lp_word_o,
    output logic        lp_valid_o,
    output logic        done_o,
    output logic        fail_o,
    output logic        speed100_o,
    output logic        full_dup_o
);
    localparam int CNT_W = (MATCH_N > 2) ? $clog2(MATCH_N) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MATCH_N - 1);

    typedef struct packed {
        phase_e           ph;
        cw_t              cand;
        logic [CNT_W-1:0] cnt;
        cw_t              lp;
        logic             lp_vld;
        logic             ack;
        logic             done;
        logic             fail;
        logic             spd100;
        logic             fdx;
    } arb_st_t;

    arb_st_t st_d, st_q, fresh;

    logic en_q, restart_q;
    cw_t  adv_q;
    logic tmo, run, restart_evt;
    logic [TECH_N-1:0] pick;
    logic none, r_spd, r_fdx;
    cw_t  rx_bare;

    an_ctl_regs #(.ADV_RESET(ADV_RESET)) i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl_i    (ctl_wr_i),
        .wd_en_i     (ctl_en_wd_i),
        .wd_restart_i(ctl_restart_wd_i),
        .wr_adv_i    (adv_wr_i),
        .wd_adv_i    (adv_wd_i),
        .en_o        (en_q),
        .restart_o   (restart_q),
        .adv_o       (adv_q)
    );

    assign run = (st_q.ph == PH_ABIL) || (st_q.ph == PH_ACK);

    an_neg_timer #(.LIMIT(TIMEOUT_CYC)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clr_i    (restart_evt),
        .expired_o(tmo)
    );

    an_prio_resolve i_res (
        .loc_i   (adv_q[TECH_LSB +: TECH_N]),
        .lp_i    (st_q.lp[TECH_LSB +: TECH_N]),
        .pick_o  (pick),
        .none_o  (none),
        .spd100_o(r_spd),
        .fdx_o   (r_fdx)
    );

    assign rx_bare = strip_ack(rx_word_i);

    always_comb begin
        fresh        = st_q;
        fresh.ph     = PH_ABIL;
        fresh.cnt    = '0;
        fresh.lp_vld = 1'b0;
        fresh.ack    = 1'b0;
        fresh.done   = 1'b0;
        fresh.spd100 = 1'b0;
        fresh.fdx    = 1'b0;
    end

    always_comb begin
        st_d        = st_q;
        restart_evt = 1'b0;
        if (!en_q) begin
            st_d      = fresh;
            st_d.ph   = PH_OFF;
            st_d.fail = 1'b0;
        end else if (restart_q || st_q.ph == PH_OFF) begin
            st_d        = fresh;
            st_d.fail   = 1'b0;
            restart_evt = 1'b1;
        end else begin
            unique case (st_q.ph)
                PH_ABIL: begin
                    if (tmo) begin
                        st_d        = fresh;
                        st_d.fail   = 1'b1;
                        restart_evt = 1'b1;
                    end else if (idle100_i || idle10_i) begin
                        st_d.ph     = PH_DONE;
                        st_d.done   = 1'b1;
                        st_d.fail   = 1'b0;
                        st_d.cnt    = '0;
                        st_d.spd100 = idle100_i;
                        st_d.fdx    = 1'b0;
                    end else if (rx_valid_i) begin
                        if (st_q.cnt != '0 && rx_bare == strip_ack(st_q.cand)) begin
                            if (st_q.cnt == CNT_LAST) begin
                                st_d.ph     = PH_ACK;
                                st_d.lp     = rx_word_i;
                                st_d.lp_vld = 1'b1;
                                st_d.ack    = 1'b1;
                                st_d.cnt    = '0;
                            end else begin
                                st_d.cnt = st_q.cnt + CNT_W'(1);
                            end
                        end else begin
                            st_d.cand = rx_word_i;
                            st_d.cnt  = CNT_W'(1);
                        end
                    end
                end
                PH_ACK: begin
                    if (tmo) begin
                        st_d        = fresh;
                        st_d.fail   = 1'b1;
                        restart_evt = 1'b1;
                    end else if (rx_valid_i) begin
                        if (rx_word_i[ACK_BIT] && rx_bare == strip_ack(st_q.lp)) begin
                            if (st_q.cnt == CNT_LAST) begin
                                if (none) begin
                                    st_d        = fresh;
                                    st_d.fail   = 1'b1;
                                    restart_evt = 1'b1;
                                end else begin
                                    st_d.ph     = PH_DONE;
                                    st_d.done   = 1'b1;
                                    st_d.fail   = 1'b0;
                                    st_d.cnt    = '0;
                                    st_d.spd100 = r_spd;
                                    st_d.fdx    = r_fdx;
                                end
                            end else begin
                                st_d.cnt = st_q.cnt + CNT_W'(1);
                            end
                        end else begin
                            st_d.cnt = '0;
                        end
                    end
                end
                PH_DONE: begin
                    if (!link_ok_i) begin
                        st_d        = fresh;
                        restart_evt = 1'b1;
                    end
                end
                default: begin
                    st_d        = fresh;
                    restart_evt = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ph     <= PH_ABIL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_en_o      = en_q;
    assign ctl_restart_o = restart_q;
    assign adv_o         = adv_q;
    assign tx_req_o      = run;
    assign tx_word_o     = st_q.ack ? (adv_q | ACK_MASK) : strip_ack(adv_q);
    assign lp_word_o     = st_q.lp;
    assign lp_valid_o    = st_q.lp_vld;
    assign done_o        = st_q.done;
    assign fail_o        = st_q.fail;
    assign speed100_o    = st_q.spd100;
    assign full_dup_o    = st_q.fdx;

    // R3
    ack_needs_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_o[ACK_BIT] |-> lp_valid_o);

    // R5
    pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    // R6
    fail_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (tx_req_o && !lp_valid_o && !done_o));

    // R8
    tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && en_q && !restart_q) |=> fail_o);

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!tx_req_o && !done_o && !fail_o));

    // R11
    link_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !link_ok_i) |=> !done_o);

    // R13
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
endmodule

// File: tb/test_autoneg_arbiter.sv
`timescale 1ns/1ps
module test_autoneg_arbiter;
    localparam int TMO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_en_wd = 1'b0, ctl_rs_wd = 1'b0;
    logic        adv_wr = 1'b0;
    logic [15:0] adv_wd = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic        idle10 = 1'b0, idle100 = 1'b0, link_ok = 1'b1;
    logic        ctl_en_o, ctl_restart_o, tx_req_o, lp_valid_o, done_o, fail_o, speed100_o, full_dup_o;
    logic [15:0] adv_o, tx_word_o, lp_word_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    autoneg_arbiter #(.TIMEOUT_CYC(TMO)) i_autoneg_arbiter (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .ctl_en_wd_i(ctl_en_wd), .ctl_restart_wd_i(ctl_rs_wd),
        .adv_wr_i(adv_wr), .adv_wd_i(adv_wd),
        .rx_valid_i(rx_valid), .rx_word_i(rx_word),
        .idle10_i(idle10), .idle100_i(idle100), .link_ok_i(link_ok),
        .ctl_en_o(ctl_en_o), .ctl_restart_o(ctl_restart_o), .adv_o(adv_o),
        .tx_req_o(tx_req_o), .tx_word_o(tx_word_o),
        .lp_word_o(lp_word_o), .lp_valid_o(lp_valid_o),
        .done_o(done_o), .fail_o(fail_o),
        .speed100_o(speed100_o), .full_dup_o(full_dup_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_en, m_rs, m_ack, m_lpv, m_done, m_fail, m_spd, m_fdx;
    logic [15:0] m_adv, m_cand, m_lp;
    int          m_ph, m_cnt, m_tmr;
    bit          o_en, o_rs, run, tmo, evt;
    logic [15:0] o_adv;
    logic [3:0]  common;

    task automatic go_fresh();
        m_ph = 1; m_cnt = 0; m_ack = 0; m_lpv = 0; m_done = 0; m_spd = 0; m_fdx = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 1; m_rs = 0; m_adv = 16'h01E1;
            m_ph = 1; m_cand = 0; m_cnt = 0; m_lp = 0; m_lpv = 0; m_ack = 0;
            m_done = 0; m_fail = 0; m_spd = 0; m_fdx = 0; m_tmr = 0;
        end else begin
            o_en = m_en; o_rs = m_rs; o_adv = m_adv;
            m_rs = ctl_wr && ctl_rs_wd;
            if (ctl_wr) m_en = ctl_en_wd;
            if (adv_wr) m_adv = adv_wd;
            run = (m_ph == 1) || (m_ph == 2);
            tmo = run && (m_tmr == TMO - 1);
            evt = 0;
            if (!o_en) begin
                go_fresh(); m_ph = 0; m_fail = 0;
            end else if (o_rs || m_ph == 0) begin
                go_fresh(); m_fail = 0; evt = 1;
            end else if (m_ph == 1) begin
                if (tmo) begin
                    go_fresh(); m_fail = 1; evt = 1;
                end else if (idle100 || idle10) begin
                    m_ph = 3; m_done = 1; m_fail = 0; m_cnt = 0; m_spd = idle100; m_fdx = 0;
                end else if (rx_valid) begin
                    if (m_cnt != 0 && (rx_word & 16'hBFFF) == (m_cand & 16'hBFFF)) begin
                        if (m_cnt == 2) begin
                            m_ph = 2; m_lp = rx_word; m_lpv = 1; m_ack = 1; m_cnt = 0;
                        end else m_cnt++;
                    end else begin
                        m_cand = rx_word; m_cnt = 1;
                    end
                end
            end else if (m_ph == 2) begin
                if (tmo) begin
                    go_fresh(); m_fail = 1; evt = 1;
                end else if (rx_valid) begin
                    if (rx_word[14] && (rx_word & 16'hBFFF) == (m_lp & 16'hBFFF)) begin
                        if (m_cnt == 2) begin
                            common = o_adv[8:5] & m_lp[8:5];
                            if (common == 4'b0) begin
                                go_fresh(); m_fail = 1; evt = 1;
                            end else begin
                                m_ph = 3; m_done = 1; m_fail = 0; m_cnt = 0;
                                if (common[3]) begin m_spd = 1; m_fdx = 1; end
                                else if (common[2]) begin m_spd = 1; m_fdx = 0; end
                                else if (common[1]) begin m_spd = 0; m_fdx = 1; end
                                else begin m_spd = 0; m_fdx = 0; end
                            end
                        end else m_cnt++;
                    end else m_cnt = 0;
                end
            end else if (m_ph == 3) begin
                if (!link_ok) begin go_fresh(); evt = 1; end
            end
            m_tmr = (evt || !run) ? 0 : m_tmr + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 ctl_en", ctl_en_o, m_en);
            chk("R9 restart", ctl_restart_o, m_rs);
            chk("R12 adv", adv_o, m_adv);
            chk("R10 tx_req", tx_req_o, (m_ph == 1 || m_ph == 2));
            chk("R3 tx_word", tx_word_o, m_ack ? (m_adv | 16'h4000) : (m_adv & 16'hBFFF));
            chk("R2 lp_valid", lp_valid_o, m_lpv);
            if (m_lpv) chk("R2 lp_word", lp_word_o, m_lp);
            chk("R4 done", done_o, m_done);
            chk("R6 fail", fail_o, m_fail);
            chk("R5 speed", speed100_o, m_spd);
            chk("R5 duplex", full_dup_o, m_fdx);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [15:0] w);
        rx_valid = 1'b1; rx_word = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic write_ctl(input logic en, input logic rs);
        ctl_wr = 1'b1; ctl_en_wd = en; ctl_rs_wd = rs;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_rs_wd = 1'b0;
    endtask

    task automatic write_adv(input logic [15:0] v);
        adv_wr = 1'b1; adv_wd = v;
        @(negedge clk);
        adv_wr = 1'b0;
    endtask

    task automatic restart_neg();
        write_ctl(1'b1, 1'b1);
        wait_n(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", ctl_en_o, 1);
        chk("R1 restart", ctl_restart_o, 0);
        chk("R1 adv", adv_o, 16'h01E1);
        chk("R1 tx_req", tx_req_o, 1);
        chk("R1 tx_word", tx_word_o, 16'h01E1);
        chk("R1 done", done_o, 0);
        chk("R1 fail", fail_o, 0);
        chk("R1 lp_valid", lp_valid_o, 0);

        // R2/R3/R4/R5: full negotiation, 100 full common
        put(16'h01A1); put(16'h01A1);
        chk("R2 not yet", lp_valid_o, 0);
        put(16'h01A1);
        chk("R2 latched", lp_valid_o, 1);
        chk("R2 lp_word", lp_word_o, 16'h01A1);
        chk("R3 ack out", tx_word_o, 16'h41E1);
        put(16'h41A1); put(16'h41A1);
        chk("R4 not yet", done_o, 0);
        put(16'h41A1);
        chk("R4 done", done_o, 1);
        chk("R5 speed 100fd", speed100_o, 1);
        chk("R5 duplex 100fd", full_dup_o, 1);

        // R11 loss of link
        link_ok = 1'b0; @(negedge clk); link_ok = 1'b1;
        chk("R11 done cleared", done_o, 0);
        chk("R11 tx_req", tx_req_o, 1);
        chk("R11 ack cleared", tx_word_o, 16'h01E1);

        // R2 candidate replacement, bit 14 ignored in first phase
        put(16'h0021); put(16'h0021); put(16'h0041); put(16'h4041);
        chk("R2 restarted count", lp_valid_o, 0);
        put(16'h0041);
        chk("R2 latched new", lp_word_o, 16'h0041);
        // R4 a word without ack clears the count
        put(16'h4041); put(16'h4041); put(16'h0041); put(16'h4041); put(16'h4041);
        chk("R4 count cleared", done_o, 0);
        put(16'h4041);
        chk("R4 done after reset count", done_o, 1);
        chk("R5 speed 10fd", speed100_o, 0);
        chk("R5 duplex 10fd", full_dup_o, 1);

        // R12/R6: local only 10 half, partner only 100 -> no common
        write_adv(16'h0021);
        restart_neg();
        chk("R12 tx_word", tx_word_o, 16'h0021);
        put(16'h0181); put(16'h0181); put(16'h0181);
        put(16'hC181 & 16'h41FF); put(16'h4181); put(16'h4181);
        chk("R6 fail", fail_o, 1);
        chk("R6 lp cleared", lp_valid_o, 0);
        chk("R6 done", done_o, 0);

        // R9 restart clears fail
        write_adv(16'h01E1);
        write_ctl(1'b1, 1'b1);
        chk("R9 restart reads 1", ctl_restart_o, 1);
        @(negedge clk);
        chk("R9 restart cleared", ctl_restart_o, 0);
        chk("R9 fail cleared", fail_o, 0);

        // R7 parallel detection
        idle10 = 1'b1; @(negedge clk); idle10 = 1'b0;
        chk("R7 10 done", done_o, 1);
        chk("R7 10 speed", speed100_o, 0);
        chk("R7 10 half", full_dup_o, 0);
        idle100 = 1'b1; @(negedge clk); idle100 = 1'b0;
        chk("R7 ignored when done", speed100_o, 0);
        restart_neg();
        idle10 = 1'b1; idle100 = 1'b1; @(negedge clk); idle10 = 1'b0; idle100 = 1'b0;
        chk("R7 100 wins", speed100_o, 1);
        chk("R7 100 half", full_dup_o, 0);

        // R8 timeout, then R13 success clears fail
        restart_neg();
        wait_n(TMO + 5);
        chk("R8 timeout fail", fail_o, 1);
        chk("R8 still negotiating", tx_req_o, 1);
        idle10 = 1'b1; @(negedge clk); idle10 = 1'b0;
        chk("R13 done", done_o, 1);
        chk("R13 fail cleared", fail_o, 0);

        // R10 disable
        write_ctl(1'b0, 1'b0);
        wait_n(1);
        chk("R10 tx_req off", tx_req_o, 0);
        chk("R10 done off", done_o, 0);
        put(16'h01A1); put(16'h01A1); put(16'h01A1);
        idle10 = 1'b1; @(negedge clk); idle10 = 1'b0;
        chk("R10 words ignored", lp_valid_o, 0);
        chk("R10 idle ignored", done_o, 0);
        write_ctl(1'b1, 1'b0);
        wait_n(1);
        chk("R10 re-enabled", tx_req_o, 1);
        put(16'h0081); put(16'h0081); put(16'h0081);
        put(16'h4081); put(16'h4081); put(16'h4081);
        chk("R5 100 half", speed100_o, 1);
        chk("R5 100 half duplex", full_dup_o, 0);

        wait_n(3);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule